// File: doc/BRIEF.md
# Variable-Page-Size Associative TLB

The block is a fully associative translation buffer. Each slot keeps a 64-bit tag word and a 64-bit translation word. A write port loads both words into a chosen slot. A direct read port returns the translation word of one slot, picked by an address.

The associative port compares a 64-bit probe word against every slot in parallel. It returns the translation word of the lowest-numbered valid slot that matches, together with a hit flag.

Every slot sets its own compare mask from a size code carried in its translation word. One array therefore holds pages of four different sizes. Both read results are registered and appear one clock after their inputs.

Top module: `vpt_tlb`

## Requirements
- R1: The array holds NUM_ENTRIES slots (64 by default). When `wr_en_i` is high at a clock edge, `wr_tag_i` and `wr_data_i` are stored into slot `wr_idx_i`, and the new contents are visible to both read ports from the next cycle.
- R2: A slot takes part in lookup only while bit 63 of its translation word (valid) is 1.
- R3: Bits 62:61 of a slot's translation word select that slot's compare mask:
  - code 0 compares all 64 bits;
  - code 1 leaves bits 15:12 out of the compare;
  - code 2 leaves bits 18:12 out of the compare;
  - code 3 leaves bits 21:12 out of the compare.
- R4: A slot matches when its tag AND its mask equals the probe AND the same mask.
- R5: When several slots match, the lowest slot index wins and its translation word is returned.
- R6: `lk_hit_o` and `lk_data_o` reflect the probe presented on `lk_probe_i` one clock edge earlier.
- R7: The direct read selects the slot with `rd_addr_i[8:3]` and ignores the other address bits. It returns that slot's translation word whatever its valid bit holds, one clock edge after the address is presented.
- R8: When no slot matches, `lk_hit_o` is 0 and `lk_data_o` is zero.
- R9: A write in the same cycle as a lookup or direct read does not change that result. The written value is seen from the following cycle.
- R10: An active-low reset clears every slot to zero, so that:
  - no lookup hits after reset;
  - direct reads return zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 6 | Slot written |
| wr_tag_i | input | 64 | Tag word to store |
| wr_data_i | input | 64 | Translation word to store |
| rd_addr_i | input | 9 | Direct read address, slot in bits 8:3 |
| rd_data_o | output | 64 | Translation word of the addressed slot |
| lk_probe_i | input | 64 | Associative probe word |
| lk_hit_o | output | 1 | Lookup found a valid matching slot |
| lk_data_o | output | 64 | Translation word of the winning slot, zero on miss |

## Verification
The bench builds the block with its default parameters: 64 slots of 64-bit words. This makes slot 63, the full six-bit read index and the page-size field at bits 62:61 reachable. With these widths, probes can be placed just inside and just outside each of the three masked ranges. Priority is checked with two identical tags in adjacent slots. Same-cycle write and lookup collisions are exercised, as are reads of slots whose valid bit is clear.

// File: rtl/vpt_tlb_pkg.sv
package vpt_tlb_pkg;
  localparam int unsigned WORD_W    = 64;
  localparam int unsigned VALID_BIT = 63;
  localparam int unsigned SIZE_LSB  = 61;
  localparam int unsigned PAGE_LSB  = 12;

  typedef enum logic [1:0] {
    PG_BASE = 2'd0,
    PG_X16  = 2'd1,
    PG_X128 = 2'd2,
    PG_X1K  = 2'd3
  } pg_size_e;

  // Compare mask for one slot, chosen by its own size code.
  function automatic logic [WORD_W-1:0] cmp_mask(input pg_size_e sz);
    logic [WORD_W-1:0] m;
    m = '1;
    unique case (sz)
      PG_X16:  m[PAGE_LSB+3:PAGE_LSB] = '0;
      PG_X128: m[PAGE_LSB+6:PAGE_LSB] = '0;
      PG_X1K:  m[PAGE_LSB+9:PAGE_LSB] = '0;
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vpt_tlb_store.sv
module vpt_tlb_store
  import vpt_tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [IDX_W-1:0]                   wr_idx_i,
  input  logic [WORD_W-1:0]                  wr_tag_i,
  input  logic [WORD_W-1:0]                  wr_data_i,
  output logic [NUM_ENTRIES-1:0][WORD_W-1:0] tag_o,
  output logic [NUM_ENTRIES-1:0][WORD_W-1:0] data_o
);
  logic [NUM_ENTRIES-1:0][WORD_W-1:0] tag_q, data_q;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        tag_q[g]  <= wr_tag_i;
        data_q[g] <= wr_data_i;
      end
    end
  end

  assign tag_o  = tag_q;
  assign data_o = data_q;
endmodule

// File: rtl/vpt_tlb_match.sv
module vpt_tlb_match
  import vpt_tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64
) (
  input  logic [NUM_ENTRIES-1:0][WORD_W-1:0] tag_i,
  input  logic [NUM_ENTRIES-1:0][WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0]                  probe_i,
  output logic [NUM_ENTRIES-1:0]             match_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic [WORD_W-1:0] mask;
    assign mask = cmp_mask(pg_size_e'(data_i[g][SIZE_LSB+1:SIZE_LSB]));
    assign match_o[g] = data_i[g][VALID_BIT] &&
                        ((tag_i[g] & mask) == (probe_i & mask));
  end
endmodule

// File: rtl/vpt_tlb_pick.sv
module vpt_tlb_pick
  import vpt_tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_ENTRIES-1:0]             req_i,
  input  logic [NUM_ENTRIES-1:0][WORD_W-1:0] data_i,
  output logic                               hit_o,
  output logic [WORD_W-1:0]                  data_o
);
  logic [NUM_ENTRIES-1:0] gnt;

  // Lowest index first.
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (req_i[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      data_o = data_o | ({WORD_W{gnt[i]}} & data_i[i]);
    end
  end

  assign hit_o = |gnt;

  p_one_winner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));
  p_gnt_is_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt & ~req_i) == '0);
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
  import vpt_tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned ADDR_LSB    = 3,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
  localparam int unsigned RD_ADDR_W  = ADDR_LSB + IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [WORD_W-1:0]    wr_tag_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  input  logic [RD_ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0]    rd_data_o,
  input  logic [WORD_W-1:0]    lk_probe_i,
  output logic                 lk_hit_o,
  output logic [WORD_W-1:0]    lk_data_o
);
  logic [NUM_ENTRIES-1:0][WORD_W-1:0] tag_arr, data_arr;
  logic [NUM_ENTRIES-1:0]             match;
  logic                               hit_d;
  logic [WORD_W-1:0]                  lk_data_d;
  logic [IDX_W-1:0]                   rd_idx;
  logic                               unused_addr_lo;

  assign rd_idx         = rd_addr_i[RD_ADDR_W-1:ADDR_LSB];
  assign unused_addr_lo = ^rd_addr_i[ADDR_LSB-1:0];

  vpt_tlb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_tag_i  (wr_tag_i),
    .wr_data_i (wr_data_i),
    .tag_o     (tag_arr),
    .data_o    (data_arr)
  );

  vpt_tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .tag_i   (tag_arr),
    .data_i  (data_arr),
    .probe_i (lk_probe_i),
    .match_o (match)
  );

  vpt_tlb_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (match),
    .data_i (data_arr),
    .hit_o  (hit_d),
    .data_o (lk_data_d)
  );

  // Results sample the array before any same-cycle write lands.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_hit_o  <= 1'b0;
      lk_data_o <= '0;
      rd_data_o <= '0;
    end else begin
      lk_hit_o  <= hit_d;
      lk_data_o <= lk_data_d;
      rd_data_o <= data_arr[rd_idx];
    end
  end

  p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> lk_data_o == '0);
  p_hit_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_data_o[VALID_BIT]);
  p_rd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_addr_i) && !$past(wr_en_i)) |=> $stable(rd_data_o));
  p_lk_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(lk_probe_i) && !$past(wr_en_i)) |=> ($stable(lk_data_o) && $stable(lk_hit_o)));
endmodule

// File: tb/vpt_tlb_tb_top.sv
module vpt_tlb_tb_top;
  localparam int unsigned CLK_PERIOD = 10;

  localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] S1 = 64'h2000_0000_0000_0000;
  localparam logic [63:0] S2 = 64'h4000_0000_0000_0000;
  localparam logic [63:0] S3 = 64'h6000_0000_0000_0000;

  localparam logic [63:0] D0  = V | 64'hA0;
  localparam logic [63:0] D5  = V | S1 | 64'h55;
  localparam logic [63:0] D9  = V | S2 | 64'h99;
  localparam logic [63:0] D20 = V | S3 | 64'h77;
  localparam logic [63:0] D30 = S3 | 64'h33;
  localparam logic [63:0] D40 = V | 64'h40;
  localparam logic [63:0] D41 = V | 64'h41;
  localparam logic [63:0] D63 = V | 64'h63;

  typedef struct packed {
    logic [63:0] probe;
    logic        hit;
    logic [63:0] data;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{64'h0000_1234_5678_9000, 1'b1, D0},   // R4 exact, code 0
    '{64'h0000_1234_5678_8000, 1'b0, 64'h0}, // R3 code 0 compares bit 12
    '{64'h0000_0000_00AB_F000, 1'b1, D5},   // R3 code 1 ignores 15:12
    '{64'h0000_0000_00AA_C000, 1'b0, 64'h0}, // R3 code 1 compares bit 16
    '{64'h0000_0000_0F07_F000, 1'b1, D9},   // R3 code 2 ignores 18:12
    '{64'h0000_0000_0F08_0000, 1'b0, 64'h0}, // R3 code 2 compares bit 19
    '{64'h0000_0000_403F_F000, 1'b1, D20},  // R3 code 3 ignores 21:12
    '{64'h0000_0000_DEAD_0000, 1'b0, 64'h0}, // R2 invalid slot skipped
    '{64'h0000_0000_CAFE_0000, 1'b1, D40},  // R5 lowest index wins
    '{64'hFFFF_0000_0000_F000, 1'b1, D63},  // R1 top slot
    '{64'h0,                   1'b0, 64'h0}  // R8 miss on cleared slots
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_tag = '0, wr_data = '0;
  logic [8:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic [63:0] lk_probe = '0;
  logic        lk_hit;
  logic [63:0] lk_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpt_tlb dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_tag_i   (wr_tag),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .lk_probe_i (lk_probe),
    .lk_hit_o   (lk_hit),
    .lk_data_o  (lk_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [63:0] tag, input logic [63:0] data);
    wr_en = 1'b1; wr_idx = idx; wr_tag = tag; wr_data = data;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R10: reset state
    lk_probe = '0; rd_addr = '0;
    @(posedge clk); #1;
    chk("R10 hit after reset", {63'h0, lk_hit}, 64'h0);
    chk("R10 lookup data after reset", lk_data, 64'h0);
    chk("R10 read after reset", rd_data, 64'h0);

    wr(6'd0,  64'h0000_1234_5678_9000, D0);
    wr(6'd5,  64'h0000_0000_00AB_C000, D5);
    wr(6'd9,  64'h0000_0000_0F00_0000, D9);
    wr(6'd20, 64'h0000_0000_4000_0000, D20);
    wr(6'd30, 64'h0000_0000_DEAD_0000, D30);
    wr(6'd40, 64'h0000_0000_CAFE_0000, D40);
    wr(6'd41, 64'h0000_0000_CAFE_0000, D41);
    wr(6'd63, 64'hFFFF_0000_0000_F000, D63);

    // R3 R4 R5 R6 R8: table, one result per edge
    for (int i = 0; i < NVEC; i++) begin
      lk_probe = VECS[i].probe;
      @(posedge clk); #1;
      checks++;
      if (lk_hit !== VECS[i].hit || lk_data !== VECS[i].data) begin
        errors++;
        $display("FAIL R4/R6 row %0d actual=%b/%h expected=%b/%h",
                 i, lk_hit, lk_data, VECS[i].hit, VECS[i].data);
      end
    end

    // R7: invalid slot still readable, low and high address bits
    rd_addr = {6'd30, 3'b111};
    @(posedge clk); #1;
    chk("R7 read invalid slot", rd_data, D30);
    rd_addr = {6'd63, 3'b000};
    @(posedge clk); #1;
    chk("R7 read top slot", rd_data, D63);

    // R9: same-cycle write does not affect lookup or read
    lk_probe = 64'h0000_0000_CAFE_0000;
    rd_addr  = {6'd40, 3'b000};
    wr_en = 1'b1; wr_idx = 6'd40; wr_tag = 64'h0000_0000_CAFE_0000; wr_data = 64'h40;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R9 lookup during write", lk_data, D40);
    chk("R9 read during write", rd_data, D40);
    @(posedge clk); #1;
    chk("R9 lookup after write", lk_data, D41);
    chk("R1 read after write", rd_data, 64'h40);

    // R1: overwrite tag and data of one slot
    wr(6'd5, 64'h0000_0000_1111_0000, D5 | 64'h100);
    lk_probe = 64'h0000_0000_1111_F000;
    rd_addr  = {6'd5, 3'b010};
    @(posedge clk); #1;
    chk("R1 lookup new tag", lk_data, D5 | 64'h100);
    chk("R1 read new data", rd_data, D5 | 64'h100);

    // R10: reset mid-run clears everything
    #1 rst_ni = 1'b0;
    @(posedge clk); #1;
    rst_ni = 1'b1;
    lk_probe = 64'h0000_1234_5678_9000;
    rd_addr  = {6'd63, 3'b000};
    @(posedge clk); #1;
    chk("R10 no hit after second reset", {63'h0, lk_hit}, 64'h0);
    chk("R10 read zero after second reset", rd_data, 64'h0);

    finish_run();
  end
endmodule